// File: doc/BRIEF.md
# Per-CPU Interrupt Summary and Mask

This block gathers every interrupt class aimed at one processor and presents it two ways. It holds a summary word that software reads to see what is pending, and it drives one request line per class toward the processor, each gated by a per-class enable. The classes are a halt requested from the node configuration logic, a console halt, a periodic clock tick, an interprocessor call, a serial-port (UART) interrupt and four device interrupt levels. Each device level also reports, through a small field in the summary word, which bus node raised it.

The four one-shot classes (console halt, clock, interprocessor call, UART) arrive as single-cycle strobes. They are latched until software acknowledges them by writing a one to their summary bit. The device levels and the halt request are live: their summary bits follow the inputs and cannot be acknowledged from the register port. The register port is a plain single-cycle read/write port with a one-bit select (enable word or summary word). It has no stream traffic, so there is no valid/ready handshake and no back-pressure. A write takes effect at the next clock edge, and a read returns the selected word combinationally.

Top module: `cpu_irq_summary`

## Requirements
- R1: After reset the enable word reads 0, the summary word reads 0 and every request output is low.
- R2: The enable word has 9 bits: bit 0 UART, bits 1 to 4 device levels 0 to 3, bit 5 interprocessor call, bit 6 clock, bit 7 halt, bit 8 console halt. A write with select 0 loads it at the next edge, and it reads back zero-extended, so bits 9 to 31 read 0.
- R3: A strobe on a one-shot class sets its summary bit at the next edge: UART bit 0, interprocessor call bit 5, clock bit 6, console halt bit 27. The bit then stays set until it is acknowledged.
- R4: A write with select 1 clears each one-shot summary bit whose write-data bit is 1 and leaves bits written 0 unchanged. The same write has no effect on any other summary bit.
- R5: If a strobe arrives in the same cycle as the acknowledge of its bit, the bit stays set.
- R6: Summary bits 1 to 4 equal device levels 0 to 3 as sampled at the previous edge, and software writes do not change them.
- R7: The 5-bit field for device level k sits at summary bits 7+5k to 11+5k. It captures that level's node number at the edge where the level is first seen high. Node changes while the level stays high are ignored, and the field keeps its value after the level falls, until the next rise.
- R8: Summary bit 28 equals the halt request as sampled at the previous edge, and writes to the summary word do not change it.
- R9: Each request output is high exactly when its class is pending and its enable bit is set. A disabled class still shows as pending in the summary word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Live halt request from node configuration |
| conhalt_evt | input | 1 | Console-halt strobe |
| clock_evt | input | 1 | Clock-tick strobe |
| ipi_evt | input | 1 | Interprocessor-call strobe |
| uart_evt | input | 1 | UART interrupt strobe |
| dev_level | input | NUM_LVL | Live device interrupt levels, level 0 in bit 0 |
| dev_node | input | NUM_LVL*NODE_W | Node number per level, level k in bits [k*NODE_W +: NODE_W] |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable word, 1 selects the summary word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected word |
| irq_uart | output | 1 | UART request |
| irq_dev | output | NUM_LVL | Device level requests |
| irq_ipi | output | 1 | Interprocessor-call request |
| irq_clock | output | 1 | Clock request |
| irq_halt | output | 1 | Halt request |
| irq_conhalt | output | 1 | Console-halt request |

## Verification
The bench builds the block with its default values: four device levels, 5-bit node numbers and a 32-bit word. These values produce the exact layout that software decodes: a 9-bit enable word, node fields at bits 7, 12, 17 and 22, and console halt and halt at bits 27 and 28. With this layout the bench can check each field position, the top device level's field against its neighbours, and the edge-versus-acknowledge collision using literal expected words.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;

  // Slot of each one-shot class inside the pending-edge vector
  typedef enum logic [1:0] {
    EDGE_UART    = 2'd0,
    EDGE_IPI     = 2'd1,
    EDGE_CLOCK   = 2'd2,
    EDGE_CONHALT = 2'd3
  } edge_idx_e;

  localparam int NUM_EDGE = 4;

  // Register port select
  typedef enum logic {
    SEL_ENABLE  = 1'b0,
    SEL_SUMMARY = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);

  logic [WIDTH-1:0] pend_q;

  // Set dominates clear so a strobe is never lost to an acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track #(
  parameter int NUM_LVL = 4,
  parameter int NODE_W  = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LVL-1:0]         lvl_i,
  input  logic [NUM_LVL*NODE_W-1:0]  node_i,
  output logic [NUM_LVL-1:0]         lvl_o,
  output logic [NUM_LVL*NODE_W-1:0]  src_o
);

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic              seen_q;
    logic [NODE_W-1:0] src_q;
    logic              rise;

    assign rise = lvl_i[g] & ~seen_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seen_q <= 1'b0;
        src_q  <= '0;
      end else begin
        seen_q <= lvl_i[g];
        if (rise) src_q <= node_i[g*NODE_W +: NODE_W];
      end
    end

    assign lvl_o[g]                  = seen_q;
    assign src_o[g*NODE_W +: NODE_W] = src_q;
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int MASK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [MASK_W-1:0] wdata_i,
  output logic [MASK_W-1:0] mask_o
);

  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_en_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/cpu_irq_summary.sv
module cpu_irq_summary
  import irq_sum_pkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int NODE_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      halt_req,
  input  logic                      conhalt_evt,
  input  logic                      clock_evt,
  input  logic                      ipi_evt,
  input  logic                      uart_evt,
  input  logic [NUM_LVL-1:0]        dev_level,
  input  logic [NUM_LVL*NODE_W-1:0] dev_node,
  input  logic                      reg_wr,
  input  logic                      reg_sel,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic                      irq_uart,
  output logic [NUM_LVL-1:0]        irq_dev,
  output logic                      irq_ipi,
  output logic                      irq_clock,
  output logic                      irq_halt,
  output logic                      irq_conhalt
);

  // Summary word layout (decoded by software)
  localparam int SB_UART    = 0;
  localparam int SB_LVL0    = 1;
  localparam int SB_IPI     = NUM_LVL + 1;
  localparam int SB_CLOCK   = NUM_LVL + 2;
  localparam int SB_SRC0    = NUM_LVL + 3;
  localparam int SRC_W      = NUM_LVL * NODE_W;
  localparam int SB_CONHALT = SB_SRC0 + SRC_W;
  localparam int SB_HALT    = SB_CONHALT + 1;

  // Enable word layout
  localparam int MB_UART    = 0;
  localparam int MB_LVL0    = 1;
  localparam int MB_IPI     = NUM_LVL + 1;
  localparam int MB_CLOCK   = NUM_LVL + 2;
  localparam int MB_HALT    = NUM_LVL + 3;
  localparam int MB_CONHALT = NUM_LVL + 4;
  localparam int MASK_W     = NUM_LVL + 5;

  logic                 wr_enable;
  logic                 wr_summary;
  logic [NUM_EDGE-1:0]  edge_set;
  logic [NUM_EDGE-1:0]  edge_clr;
  logic [NUM_EDGE-1:0]  edge_pend;
  logic [NUM_LVL-1:0]   lvl_q;
  logic [SRC_W-1:0]     src_q;
  logic [MASK_W-1:0]    mask_q;
  logic                 halt_q;
  logic [DATA_W-1:0]    sum_word;

  assign wr_enable  = reg_wr && (reg_sel == SEL_ENABLE);
  assign wr_summary = reg_wr && (reg_sel == SEL_SUMMARY);

  // One-shot classes: strobe sets, write-one acknowledges
  always_comb begin
    edge_set = '0;
    edge_clr = '0;
    edge_set[EDGE_UART]    = uart_evt;
    edge_set[EDGE_IPI]     = ipi_evt;
    edge_set[EDGE_CLOCK]   = clock_evt;
    edge_set[EDGE_CONHALT] = conhalt_evt;
    if (wr_summary) begin
      edge_clr[EDGE_UART]    = reg_wdata[SB_UART];
      edge_clr[EDGE_IPI]     = reg_wdata[SB_IPI];
      edge_clr[EDGE_CLOCK]   = reg_wdata[SB_CLOCK];
      edge_clr[EDGE_CONHALT] = reg_wdata[SB_CONHALT];
    end
  end

  irq_edge_latch #(.WIDTH(NUM_EDGE)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (edge_set),
    .clr_i  (edge_clr),
    .pend_o (edge_pend)
  );

  irq_level_track #(.NUM_LVL(NUM_LVL), .NODE_W(NODE_W)) u_levels (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (dev_level),
    .node_i (dev_node),
    .lvl_o  (lvl_q),
    .src_o  (src_q)
  );

  irq_mask_reg #(.MASK_W(MASK_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_enable),
    .wdata_i (reg_wdata[MASK_W-1:0]),
    .mask_o  (mask_q)
  );

  // Halt from the configuration side is live, not software-clearable
  always_ff @(posedge clk) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_req;
  end

  always_comb begin
    sum_word = '0;
    sum_word[SB_UART]                = edge_pend[EDGE_UART];
    sum_word[SB_LVL0 +: NUM_LVL]     = lvl_q;
    sum_word[SB_IPI]                 = edge_pend[EDGE_IPI];
    sum_word[SB_CLOCK]               = edge_pend[EDGE_CLOCK];
    sum_word[SB_SRC0 +: SRC_W]       = src_q;
    sum_word[SB_CONHALT]             = edge_pend[EDGE_CONHALT];
    sum_word[SB_HALT]                = halt_q;
  end

  assign reg_rdata = (reg_sel == SEL_SUMMARY) ? sum_word
                                              : {{(DATA_W-MASK_W){1'b0}}, mask_q};

  assign irq_uart    = edge_pend[EDGE_UART]    & mask_q[MB_UART];
  assign irq_dev     = lvl_q                   & mask_q[MB_LVL0 +: NUM_LVL];
  assign irq_ipi     = edge_pend[EDGE_IPI]     & mask_q[MB_IPI];
  assign irq_clock   = edge_pend[EDGE_CLOCK]   & mask_q[MB_CLOCK];
  assign irq_halt    = halt_q                  & mask_q[MB_HALT];
  assign irq_conhalt = edge_pend[EDGE_CONHALT] & mask_q[MB_CONHALT];

endmodule

// File: rtl/irq_sum_chk.sv
module irq_sum_chk #(
  parameter int NUM_LVL = 4,
  parameter int NODE_W  = 5,
  parameter int DATA_W  = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      halt_req,
  input logic                      uart_evt,
  input logic [NUM_LVL-1:0]        dev_level,
  input logic                      reg_wr,
  input logic                      reg_sel,
  input logic [DATA_W-1:0]         reg_wdata,
  input logic [DATA_W-1:0]         sum_w,
  input logic [NUM_LVL+4:0]        mask_w,
  input logic                      irq_uart,
  input logic [NUM_LVL-1:0]        irq_dev,
  input logic                      irq_ipi,
  input logic                      irq_clock,
  input logic                      irq_halt,
  input logic                      irq_conhalt
);

  localparam int MASK_W  = NUM_LVL + 5;
  localparam int SRC0    = NUM_LVL + 3;
  localparam int SB_HALT = SRC0 + NUM_LVL * NODE_W + 1;

  logic ack_uart;
  assign ack_uart = reg_wr && reg_sel && reg_wdata[0];

  // R2
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=> (mask_w == $past(reg_wdata[MASK_W-1:0])));

  // R3
  strobe_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uart_evt |=> sum_w[0]);

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_w[0] && !uart_evt && !ack_uart) |=> sum_w[0]);

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_uart && !uart_evt) |=> !sum_w[0]);

  // R6
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sum_w[NUM_LVL:1] == $past(dev_level)));

  // R7
  src_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_w[1] |=> $stable(sum_w[SRC0 +: NODE_W]));

  // R8
  halt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sum_w[SB_HALT] == $past(halt_req)));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '0) |-> ({irq_conhalt, irq_halt, irq_clock, irq_ipi, irq_dev, irq_uart} == '0));

endmodule

bind cpu_irq_summary irq_sum_chk #(
  .NUM_LVL (NUM_LVL),
  .NODE_W  (NODE_W),
  .DATA_W  (DATA_W)
) u_irq_sum_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .halt_req    (halt_req),
  .uart_evt    (uart_evt),
  .dev_level   (dev_level),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .reg_wdata   (reg_wdata),
  .sum_w       (sum_word),
  .mask_w      (mask_q),
  .irq_uart    (irq_uart),
  .irq_dev     (irq_dev),
  .irq_ipi     (irq_ipi),
  .irq_clock   (irq_clock),
  .irq_halt    (irq_halt),
  .irq_conhalt (irq_conhalt)
);

// File: tb/test_cpu_irq_summary.sv
module test_cpu_irq_summary;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_LVL    = 4;
  localparam int NODE_W     = 5;
  localparam int DATA_W     = 32;

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic                      halt_req, conhalt_evt, clock_evt, ipi_evt, uart_evt;
  logic [NUM_LVL-1:0]        dev_level;
  logic [NUM_LVL*NODE_W-1:0] dev_node;
  logic                      reg_wr, reg_sel;
  logic [DATA_W-1:0]         reg_wdata, reg_rdata;
  logic                      irq_uart, irq_ipi, irq_clock, irq_halt, irq_conhalt;
  logic [NUM_LVL-1:0]        irq_dev;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_irq_summary #(.NUM_LVL(NUM_LVL), .NODE_W(NODE_W), .DATA_W(DATA_W)) i_cpu_irq_summary (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .conhalt_evt(conhalt_evt),
    .clock_evt(clock_evt), .ipi_evt(ipi_evt), .uart_evt(uart_evt),
    .dev_level(dev_level), .dev_node(dev_node), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_uart(irq_uart), .irq_dev(irq_dev),
    .irq_ipi(irq_ipi), .irq_clock(irq_clock), .irq_halt(irq_halt), .irq_conhalt(irq_conhalt)
  );

  // Request outputs packed in enable-word bit order
  function automatic logic [31:0] irq_vec();
    return {23'd0, irq_conhalt, irq_halt, irq_clock, irq_ipi, irq_dev, irq_uart};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] data);
    @(negedge clk);
    reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic sel, output logic [31:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  // which: 0 uart, 1 ipi, 2 clock, 3 console halt
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: uart_evt = 1'b1;
      1: ipi_evt = 1'b1;
      2: clock_evt = 1'b1;
      default: conhalt_evt = 1'b1;
    endcase
    @(negedge clk);
    uart_evt = 1'b0; ipi_evt = 1'b0; clock_evt = 1'b0; conhalt_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(1'b1, d); check("R1 summary after reset", d, 32'h0);
    rd_reg(1'b0, d); check("R1 enable after reset", d, 32'h0);
    check("R1 requests after reset", irq_vec(), 32'h0);
  endtask

  task automatic t_mask_rw();
    logic [31:0] d;
    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd_reg(1'b0, d); check("R2 enable all ones zero-extended", d, 32'h0000_01FF);
    wr_reg(1'b0, 32'h0000_00A5);
    rd_reg(1'b0, d); check("R2 enable pattern", d, 32'h0000_00A5);
    wr_reg(1'b0, 32'h0);
  endtask

  task automatic t_edge_set();
    logic [31:0] d;
    strobe(0); rd_reg(1'b1, d); check("R3 uart bit0", d, 32'h0000_0001);
    strobe(1); rd_reg(1'b1, d); check("R3 ipi bit5", d, 32'h0000_0021);
    strobe(2); rd_reg(1'b1, d); check("R3 clock bit6", d, 32'h0000_0061);
    strobe(3); rd_reg(1'b1, d); check("R3 conhalt bit27", d, 32'h0800_0061);
    repeat (3) @(negedge clk);
    rd_reg(1'b1, d); check("R3 bits held", d, 32'h0800_0061);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr_reg(1'b1, 32'h0000_0020);
    rd_reg(1'b1, d); check("R4 ack ipi only", d, 32'h0800_0041);
    wr_reg(1'b1, 32'h0);
    rd_reg(1'b1, d); check("R4 zero write keeps", d, 32'h0800_0041);
    wr_reg(1'b1, 32'h0800_0041);
    rd_reg(1'b1, d); check("R4 ack rest", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    strobe(0);
    @(negedge clk);
    uart_evt = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h1; reg_wr = 1'b1;
    @(negedge clk);
    uart_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd_reg(1'b1, d); check("R5 strobe beats ack", d, 32'h0000_0001);
    wr_reg(1'b1, 32'h1);
    rd_reg(1'b1, d); check("R5 later ack clears", d, 32'h0);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    @(negedge clk);
    dev_node = '0;
    dev_node[0 +: 5]  = 5'd9;
    dev_node[15 +: 5] = 5'd17;
    dev_level = 4'b1001;
    @(negedge clk);
    rd_reg(1'b1, d); check("R6 R7 levels 0 and 3 with nodes", d, 32'h0440_0492);
    wr_reg(1'b1, 32'hFFFF_FFFF);
    rd_reg(1'b1, d); check("R6 write cannot clear levels", d, 32'h0440_0492);
    @(negedge clk);
    dev_node[0 +: 5] = 5'd3;
    @(negedge clk);
    rd_reg(1'b1, d); check("R7 node change while high ignored", d, 32'h0440_0492);
    dev_level = 4'b1000;
    @(negedge clk);
    rd_reg(1'b1, d); check("R6 R7 level drop keeps field", d, 32'h0440_0490);
    dev_level = 4'b1001;
    @(negedge clk);
    rd_reg(1'b1, d); check("R7 new rise captures node", d, 32'h0440_0192);
    dev_level = 4'b0000;
    @(negedge clk);
    rd_reg(1'b1, d); check("R6 all levels low", d, 32'h0440_0180);
  endtask

  task automatic t_halt();
    logic [31:0] d;
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk);
    rd_reg(1'b1, d); check("R8 halt bit28 set", (d >> 28) & 32'h1, 32'h1);
    wr_reg(1'b1, 32'h1000_0000);
    rd_reg(1'b1, d); check("R8 halt not writable", (d >> 28) & 32'h1, 32'h1);
    halt_req = 1'b0;
    @(negedge clk);
    rd_reg(1'b1, d); check("R8 halt follows low", (d >> 28) & 32'h1, 32'h0);
  endtask

  task automatic t_masking();
    logic [31:0] d;
    strobe(0); strobe(1);
    rd_reg(1'b1, d); check("R9 disabled still pending", d & 32'h21, 32'h21);
    check("R9 no requests while disabled", irq_vec(), 32'h0);
    wr_reg(1'b0, 32'h001);
    check("R9 uart only enabled", irq_vec(), 32'h001);
    wr_reg(1'b0, 32'h021);
    check("R9 uart and ipi", irq_vec(), 32'h021);
    dev_level = 4'b0100; halt_req = 1'b1;
    @(negedge clk);
    check("R9 level and halt pending, not enabled", irq_vec(), 32'h021);
    wr_reg(1'b0, 32'h088);
    check("R9 level 2 and halt enabled", irq_vec(), 32'h088);
    strobe(3); strobe(2);
    wr_reg(1'b0, 32'h140);
    check("R9 conhalt and clock", irq_vec(), 32'h140);
    dev_level = 4'b0000; halt_req = 1'b0;
    wr_reg(1'b0, 32'h0);
    check("R9 all disabled", irq_vec(), 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    halt_req = 0; conhalt_evt = 0; clock_evt = 0; ipi_evt = 0; uart_evt = 0;
    dev_level = '0; dev_node = '0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask_rw();
    t_edge_set();
    t_w1c();
    t_set_wins();
    t_levels();
    t_halt();
    t_masking();
    finish_run();
  end

endmodule